// File: doc/BRIEF.md
# Two-Level Warp Issue Scheduler

This block decides, every clock cycle, which resident warp may issue an instruction. The resident warps (32 by default, each standing for 32 threads) are split into two pools. A small active pool is the only set the issue arbiter looks at. Every other warp sits in a pending pool. Keeping the arbiter narrow keeps its logic shallow, and it lets per-warp cached operand state be held only for the warps that can issue.

A warp that issues a long-latency operation, such as a global memory load, is reported on the long-latency strobe. It leaves the active pool at the next clock edge, and the block pulses a deschedule strobe with its index so that downstream storage can flush that warp's cached state. The demoted warp then waits. When the completion strobe for it arrives, it joins the tail of a first-in first-out queue of warps that are eligible for promotion. Whenever the active pool has a free slot, the warp at the head of that queue is moved in, one per cycle.

The issue grant is a plain per-cycle decision with no back-pressure. It is computed combinationally from the registered pool state and the current ready flags, and it is valid whenever any active warp is ready. Readiness, decode and dependency tracking belong to the neighbouring logic.

Top module: `warp_issue_sched`

## Requirements
- R1: After reset, warps 0 to ACTIVE_SLOTS-1 are active. The remaining warps are eligible pending warps queued in ascending index order. No warp is waiting, and the deschedule strobe is low.
- R2: At most one warp is granted per cycle. A warp that is not in the active pool is never granted, even when its ready flag is set.
- R3: `issue_valid_o` is high in a cycle exactly when at least one active warp has its `ready_i` bit set. The granted warp always has its ready bit set.
- R4: The grant goes to the first ready active warp in ascending index order, starting one past the most recently granted warp and wrapping from NUM_WARPS-1 to 0. Right after reset the search starts at warp 0.
- R5: A long-latency strobe that names an active warp removes that warp from the active pool from the next cycle on and marks it waiting. A strobe that names a warp outside the active pool has no effect.
- R6: Each demotion raises `desched_valid_o` for exactly one cycle, the cycle after the long-latency strobe, with `desched_warp_o` equal to the demoted warp. The strobe stays low in every other cycle.
- R7: A demoted warp is not promoted before its completion strobe. A completion strobe that names a warp which is not waiting has no effect.
- R8: A completion strobe appends its warp to the tail of the pending queue. When the active count at the start of a cycle is below ACTIVE_SLOTS and the queue is not empty, the head warp becomes active at that cycle's edge. At most one warp is promoted per cycle.
- R9: The active pool never holds more than ACTIVE_SLOTS warps. ACTIVE_SLOTS defaults to 8, and the values 6 and 4 are supported (any value from 1 to NUM_WARPS-1 is legal).
- R10: The grant has no back-pressure. A ready active warp is granted in the same cycle it is seen, and the round-robin pointer advances on every valid grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ready_i | input | NUM_WARPS | Per-warp ready-to-issue flags |
| longlat_valid_i | input | 1 | Long-latency operation issued by a warp this cycle |
| longlat_warp_i | input | log2(NUM_WARPS) | Warp that issued the long-latency operation |
| done_valid_i | input | 1 | A long-latency operation completed this cycle |
| done_warp_i | input | log2(NUM_WARPS) | Warp whose long-latency operation completed |
| issue_valid_o | output | 1 | A warp is granted issue this cycle |
| issue_warp_o | output | log2(NUM_WARPS) | Granted warp index |
| desched_valid_o | output | 1 | One-cycle pulse: a warp left the active pool |
| desched_warp_o | output | log2(NUM_WARPS) | Warp that left the active pool |

## Verification
The bench targets several corner cases. Warps that are ready but pending must never win; a design that arbitrates over all resident warps would grant them. A demotion and a promotion can fall in the same cycle, and the active count must use the start-of-cycle value; a design that counts the just-freed slot early would let a seventh or ninth warp into a pool of six or eight. Some strobes are stray: long-latency events for inactive warps and completions for warps that are not waiting. A careless design would desynchronise its count, push duplicate queue entries or pulse the deschedule strobe for them. The bench also checks the wrap of the round-robin pointer and the ascending promotion order of the warps queued at reset, which a pointer or preload error would break.

// File: rtl/wis_pkg.sv
package wis_pkg;
  // Default sizing of the scheduler.
  localparam int unsigned WARPS_DEFAULT  = 32;
  localparam int unsigned SLOTS_DEFAULT  = 8;
  localparam int unsigned LANES_PER_WARP = 32;

  // Smallest width able to hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wis_rr_pick.sv
module wis_rr_pick #(
  parameter int unsigned N  = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o
);
  // Scan from farthest to nearest position after last_i, so the nearest
  // requester overwrites the others and wins.
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int k = int'(N); k >= 1; k--) begin
      automatic int pos = (int'(last_i) + k) % int'(N);
      if (req_i[pos]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IW'(pos);
      end
    end
  end
endmodule

// File: rtl/wis_pend_q.sv
module wis_pend_q import wis_pkg::*; #(
  parameter int unsigned N         = 32,
  parameter int unsigned IW        = $clog2(N),
  parameter int unsigned PRE_FIRST = 8,
  parameter int unsigned PRE_CNT   = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic          nonempty_o
);
  localparam int unsigned PW    = (N < 2) ? 1 : $clog2(N);
  localparam int unsigned CW    = cnt_width(N);
  localparam int unsigned TAIL0 = PRE_CNT % N;

  logic [IW-1:0] slot_q [N];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] fill_q;
  logic          do_pop;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    return (p == PW'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign nonempty_o = (fill_q != '0);
  assign head_o     = slot_q[rd_q];
  assign do_pop     = pop_i & nonempty_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) begin
        slot_q[i] <= (i < int'(PRE_CNT)) ? IW'(int'(PRE_FIRST) + i) : '0;
      end
      rd_q   <= '0;
      wr_q   <= PW'(TAIL0);
      fill_q <= CW'(PRE_CNT);
    end else begin
      if (push_i) begin
        slot_q[wr_q] <= push_idx_i;
        wr_q         <= step_ptr(wr_q);
      end
      if (do_pop) begin
        rd_q <= step_ptr(rd_q);
      end
      case ({push_i, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/wis_pool.sv
module wis_pool import wis_pkg::*; #(
  parameter int unsigned N  = 32,
  parameter int unsigned A  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          demote_req_i,
  input  logic [IW-1:0] demote_idx_i,
  input  logic          done_req_i,
  input  logic [IW-1:0] done_idx_i,
  input  logic          promote_i,
  input  logic [IW-1:0] promote_idx_i,
  output logic [N-1:0]  act_o,
  output logic [N-1:0]  wait_o,
  output logic          slot_free_o,
  output logic          demote_ok_o,
  output logic          done_ok_o
);
  localparam int unsigned CW = cnt_width(A);

  logic [N-1:0]  act_q, wait_q;
  logic [CW-1:0] occ_q;

  assign act_o       = act_q;
  assign wait_o      = wait_q;
  assign slot_free_o = (occ_q < CW'(A));
  assign demote_ok_o = demote_req_i & act_q[demote_idx_i];
  assign done_ok_o   = done_req_i & wait_q[done_idx_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) begin
        act_q[i] <= (i < int'(A));
      end
      wait_q <= '0;
      occ_q  <= CW'(A);
    end else begin
      if (promote_i) begin
        act_q[promote_idx_i] <= 1'b1;
      end
      if (demote_ok_o) begin
        act_q[demote_idx_i]  <= 1'b0;
        wait_q[demote_idx_i] <= 1'b1;
      end
      if (done_ok_o) begin
        wait_q[done_idx_i] <= 1'b0;
      end
      case ({promote_i, demote_ok_o})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched import wis_pkg::*; #(
  parameter  int unsigned NUM_WARPS    = WARPS_DEFAULT,
  parameter  int unsigned ACTIVE_SLOTS = SLOTS_DEFAULT,
  localparam int unsigned IDX_W        = $clog2(NUM_WARPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic                 longlat_valid_i,
  input  logic [IDX_W-1:0]     longlat_warp_i,
  input  logic                 done_valid_i,
  input  logic [IDX_W-1:0]     done_warp_i,
  output logic                 issue_valid_o,
  output logic [IDX_W-1:0]     issue_warp_o,
  output logic                 desched_valid_o,
  output logic [IDX_W-1:0]     desched_warp_o
);
  logic [NUM_WARPS-1:0] act_q, wait_q, elig;
  logic                 slot_free, demote_ok, done_ok, q_nonempty, promote;
  logic [IDX_W-1:0]     q_head, last_q;

  assign elig    = act_q & ready_i;
  assign promote = slot_free & q_nonempty;

  wis_rr_pick #(.N(NUM_WARPS), .IW(IDX_W)) u_pick (
    .req_i     (elig),
    .last_i    (last_q),
    .gnt_vld_o (issue_valid_o),
    .gnt_idx_o (issue_warp_o)
  );

  wis_pend_q #(
    .N(NUM_WARPS), .IW(IDX_W),
    .PRE_FIRST(ACTIVE_SLOTS), .PRE_CNT(NUM_WARPS - ACTIVE_SLOTS)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (done_ok),
    .push_idx_i (done_warp_i),
    .pop_i      (promote),
    .head_o     (q_head),
    .nonempty_o (q_nonempty)
  );

  wis_pool #(.N(NUM_WARPS), .A(ACTIVE_SLOTS), .IW(IDX_W)) u_pool (
    .clk           (clk),
    .rst_n         (rst_n),
    .demote_req_i  (longlat_valid_i),
    .demote_idx_i  (longlat_warp_i),
    .done_req_i    (done_valid_i),
    .done_idx_i    (done_warp_i),
    .promote_i     (promote),
    .promote_idx_i (q_head),
    .act_o         (act_q),
    .wait_o        (wait_q),
    .slot_free_o   (slot_free),
    .demote_ok_o   (demote_ok),
    .done_ok_o     (done_ok)
  );

  // Round-robin pointer: last granted warp; reset value makes warp 0 first.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= IDX_W'(NUM_WARPS - 1);
    end else if (issue_valid_o) begin
      last_q <= issue_warp_o;
    end
  end

  // Deschedule pulse, one cycle after the accepted long-latency event.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desched_valid_o <= 1'b0;
      desched_warp_o  <= '0;
    end else begin
      desched_valid_o <= demote_ok;
      if (demote_ok) begin
        desched_warp_o <= longlat_warp_i;
      end
    end
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int unsigned N  = 32,
  parameter int unsigned A  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  ready_i,
  input logic          longlat_valid_i,
  input logic [IW-1:0] longlat_warp_i,
  input logic          issue_valid_o,
  input logic [IW-1:0] issue_warp_o,
  input logic          desched_valid_o,
  input logic [IW-1:0] desched_warp_o,
  input logic [N-1:0]  act,
  input logic [N-1:0]  waitm
);
  // R2: grant only from the active pool
  a_r2_grant_active: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> act[issue_warp_o]);

  // R3: granted warp is ready
  a_r3_grant_ready: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid_o |-> ready_i[issue_warp_o]);

  // R3 / R10: a ready active warp is never left idle
  a_r3_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|(act & ready_i)) |-> issue_valid_o);

  // R5: accepted event removes the warp and marks it waiting
  a_r5_demote: assert property (@(posedge clk) disable iff (!rst_n)
    (longlat_valid_i && act[longlat_warp_i]) |=>
      (!act[$past(longlat_warp_i)] && waitm[$past(longlat_warp_i)]));

  // R6: deschedule pulse follows an accepted event with its index
  a_r6_desched_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (longlat_valid_i && act[longlat_warp_i]) |=>
      (desched_valid_o && desched_warp_o == $past(longlat_warp_i)));

  // R6: no pulse without an accepted event
  a_r6_desched_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(longlat_valid_i && act[longlat_warp_i]) |=> !desched_valid_o);

  // R7: a waiting warp is never active
  a_r7_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (act & waitm) == '0);

  // R8: at most one promotion per cycle
  a_r8_one_promo: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act & ~$past(act)) <= 1);

  // R9: pool capacity
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act) <= A);
endmodule

bind warp_issue_sched wis_checker #(.N(NUM_WARPS), .A(ACTIVE_SLOTS), .IW(IDX_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ready_i         (ready_i),
  .longlat_valid_i (longlat_valid_i),
  .longlat_warp_i  (longlat_warp_i),
  .issue_valid_o   (issue_valid_o),
  .issue_warp_o    (issue_warp_o),
  .desched_valid_o (desched_valid_o),
  .desched_warp_o  (desched_warp_o),
  .act             (act_q),
  .waitm           (wait_q)
);

// File: tb/warp_issue_sched_test.sv
module warp_issue_sched_test;
  localparam int NW         = 32;
  localparam int SLOTS      = 6;   // R9: a non-default pool size
  localparam int IW         = $clog2(NW);
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NW-1:0] ready_i;
  logic          longlat_valid_i, done_valid_i;
  logic [IW-1:0] longlat_warp_i, done_warp_i;
  logic          issue_valid_o, desched_valid_o;
  logic [IW-1:0] issue_warp_o, desched_warp_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  warp_issue_sched #(.NUM_WARPS(NW), .ACTIVE_SLOTS(SLOTS)) uut (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i),
    .longlat_valid_i(longlat_valid_i), .longlat_warp_i(longlat_warp_i),
    .done_valid_i(done_valid_i), .done_warp_i(done_warp_i),
    .issue_valid_o(issue_valid_o), .issue_warp_o(issue_warp_o),
    .desched_valid_o(desched_valid_o), .desched_warp_o(desched_warp_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Behavioural reference state
  bit m_act  [NW];
  bit m_wait [NW];
  int m_queue[$];
  int m_last;
  bit m_ds_v;
  int m_ds_w;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_pick(input logic [NW-1:0] rdy);
    for (int k = 1; k <= NW; k++) begin
      int p = (m_last + k) % NW;
      if (m_act[p] && rdy[p]) return p;
    end
    return -1;
  endfunction

  // ll_mode: 0 none, 1 on the expected grant, 2 random warp
  // dn_mode: 0 none, 1 a waiting warp, 2 random warp
  task automatic step(input logic [NW-1:0] rdy, input int ll_mode, input int dn_mode);
    int eg, llw, dw, occ, p;
    bit llv, dv, dem, cmp;
    int waiters[$];
    @(negedge clk);
    eg  = m_pick(rdy);
    llv = 0; llw = 0; dv = 0; dw = 0;
    if (ll_mode == 1 && eg >= 0) begin llv = 1; llw = eg; end
    else if (ll_mode == 2) begin llv = 1; llw = $urandom_range(NW - 1); end
    for (int w = 0; w < NW; w++) if (m_wait[w]) waiters.push_back(w);
    if (dn_mode == 1 && waiters.size() > 0) begin
      dv = 1; dw = waiters[$urandom_range(waiters.size() - 1)];
    end else if (dn_mode == 2) begin
      dv = 1; dw = $urandom_range(NW - 1);
    end
    ready_i         = rdy;
    longlat_valid_i = llv;
    longlat_warp_i  = IW'(llw);
    done_valid_i    = dv;
    done_warp_i     = IW'(dw);
    #1;
    // R2 R3: validity of the grant; R4 R10: its index
    chk(issue_valid_o === (eg >= 0), "R3 grant valid", int'(issue_valid_o), int'(eg >= 0));
    if (eg >= 0)
      chk(int'(issue_warp_o) == eg, "R4 grant index", int'(issue_warp_o), eg);
    // R5 R6: deschedule pulse
    chk(desched_valid_o === m_ds_v, "R6 deschedule valid", int'(desched_valid_o), int'(m_ds_v));
    if (m_ds_v)
      chk(int'(desched_warp_o) == m_ds_w, "R6 deschedule index", int'(desched_warp_o), m_ds_w);
    // reference update (R5 R7 R8)
    occ = 0;
    for (int w = 0; w < NW; w++) occ += int'(m_act[w]);
    dem = llv && m_act[llw];
    cmp = dv && m_wait[dw];
    if (eg >= 0) m_last = eg;
    if (occ < SLOTS && m_queue.size() > 0) begin
      p = m_queue.pop_front();
      m_act[p] = 1;
    end
    if (dem) begin m_act[llw] = 0; m_wait[llw] = 1; end
    if (cmp) begin m_wait[dw] = 0; m_queue.push_back(dw); end
    m_ds_v = dem;
    m_ds_w = llw;
  endtask

  initial begin
    logic [NW-1:0] rdy;
    int r, lm, dm;
    rst_n = 1'b0; ready_i = '0;
    longlat_valid_i = 1'b0; longlat_warp_i = '0;
    done_valid_i = 1'b0; done_warp_i = '0;
    // R1: reference reset state
    for (int w = 0; w < NW; w++) begin
      m_act[w] = (w < SLOTS); m_wait[w] = 0;
      if (w >= SLOTS) m_queue.push_back(w);
    end
    m_last = NW - 1; m_ds_v = 0; m_ds_w = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(desched_valid_o === 1'b0, "R1 reset deschedule low", int'(desched_valid_o), 0);
    chk(issue_valid_o === 1'b0, "R1 reset no grant without ready", int'(issue_valid_o), 0);
    rst_n = 1'b1;
    // R4 R10: rotation with everyone ready, including the wrap
    repeat (14) step('1, 0, 0);
    // R2: only pending warps ready, nothing may be granted
    step({NW{1'b1}} << SLOTS, 0, 0);
    step({NW{1'b1}} << SLOTS, 0, 0);
    // R5 R6 R8 R1: demote granted warps, reset queue order promotes in
    step('1, 1, 0);
    repeat (9) step('1, 1, 0);
    // R5: stray long-latency events; R7: stray completions
    repeat (8) step('1, 2, 0);
    repeat (8) step('1, 0, 2);
    // R7 R8: completions return warps through the queue
    repeat (12) step('1, 0, 1);
    // R9 and mixed traffic
    for (int c = 0; c < 4000; c++) begin
      for (int w = 0; w < NW; w++) rdy[w] = ($urandom_range(3) != 0);
      if (c % 500 < 20) rdy = '0;
      r  = $urandom_range(99);
      lm = (r < 30) ? 1 : ((r < 36) ? 2 : 0);
      r  = $urandom_range(99);
      dm = (r < 30) ? 1 : ((r < 36) ? 2 : 0);
      step(rdy, lm, dm);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule